// File: doc/BRIEF.md
# Multiport Packet Receive Source

This block is the port-side sender on a byte-wide, multiport packet bus where the receiving link layer learns which port a burst belongs to from an address carried on the data lines. Each port keeps a count of packets waiting to go out. All waiting packets on a port share that port's most recently loaded byte length, first-byte seed and bad flag. The bytes of a packet are generated as seed, seed+1, seed+2 and so on, modulo 256.

When the link layer signals that it is ready and some port has a packet waiting, the source picks a port in round-robin order. It announces the port with a single address cycle, then streams the packet with valid, start, end and error markers. If the link layer withdraws its ready signal in the middle of a packet, the burst pauses and then resumes on the same port without a new address cycle. A new port may be announced in the very cycle after an end-of-packet beat.

Top module: `mpkt_rx_source`

## Requirements
- R1: `rx_sel` and `rx_val` are high in a cycle only if `lnk_rdy` was high at the clock edge that produced that cycle. No address cycle and no byte is sent while `lnk_rdy` is low.
- R2: An address cycle drives the selected port index, zero-extended, on `rx_data` with `rx_sel` high and `rx_val` low. It lasts exactly one cycle.
- R3: In the next cycle with `lnk_rdy` high after an address cycle, `rx_sel` is low, `rx_val` is high, `rx_sop` is high, and `rx_data` carries the packet's seed.
- R4: Byte i of a packet (counting from 0) is seed+i modulo 256. Every byte after the first has `rx_val` high and `rx_sop` low.
- R5: The last byte (byte length−1) carries `rx_eop` high. A one-byte packet raises `rx_sop` and `rx_eop` together.
- R6: In the cycle after an `rx_eop` beat, `rx_val` and `rx_eop` are low. An address cycle for the next waiting port may occupy that same cycle.
- R7: While `lnk_rdy` is low during a packet (including right after its address cycle), `rx_val`, `rx_sop`, `rx_eop` and `rx_err` are low and `rx_data` holds its last value. Sending resumes with the next byte and no new address cycle.
- R8: Ports with waiting packets are served in round-robin order. The search starts at the port after the one served last.
- R9: `rx_err` is high only on the `rx_eop` beat of a packet whose port was loaded with `enq_bad` set.
- R10: An enqueue with length 0 is ignored. Otherwise it adds one packet to the port's count, which saturates at 2^CNT_W−1 (7 by default). It also replaces the port's length, seed and bad flag for all of that port's packets not yet selected.
- R11: After reset all outputs are low and the round-robin search starts at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_rdy | input | 1 | Link layer ready to accept transfers |
| enq_valid | input | 1 | Enqueue one packet on `enq_port` |
| enq_port | input | AW | Target port of the enqueue |
| enq_len | input | LEN_W | Packet length in bytes (0 ignored) |
| enq_seed | input | 8 | Value of the packet's first byte |
| enq_bad | input | 1 | Mark packets as errored |
| rx_data | output | 8 | Port address or packet byte |
| rx_sel | output | 1 | Address cycle strobe |
| rx_val | output | 1 | Packet byte valid |
| rx_sop | output | 1 | First byte of packet |
| rx_eop | output | 1 | Last byte of packet |
| rx_err | output | 1 | Packet errored, on last byte |

## Verification
The assertions take for granted that `lnk_rdy` is a clean level sampled on the rising edge. They also assume `enq_port` stays below the port count, so a dequeue always finds a waiting packet. The stimulus drives all inputs only on falling edges and uses only port indices 0 to 3. It loads queues mostly while `lnk_rdy` is low, which makes every expected byte and address cycle fall on a cycle computed in advance. Pauses are introduced by lowering `lnk_rdy` right after an address cycle and right after a first byte, so the hold and resume paths are exercised.

// File: rtl/mpkt_rx_pkg.sv
package mpkt_rx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_t;

    typedef struct packed {
        logic              sel;
        logic              val;
        logic              sop;
        logic              eop;
        logic              err;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;

    function automatic rx_beat_t idle_beat(input logic [BYTE_W-1:0] d);
        rx_beat_t b;
        b      = '0;
        b.data = d;
        return b;
    endfunction
endpackage

// File: rtl/mpkt_port_queues.sv
module mpkt_port_queues
    import mpkt_rx_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int CNT_W  = 3,
    parameter int LEN_W  = 8,
    localparam int AW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           enq_valid,
    input  logic [AW-1:0]                  enq_port,
    input  logic [LEN_W-1:0]               enq_len,
    input  logic [BYTE_W-1:0]              enq_seed,
    input  logic                           enq_bad,
    input  logic                           deq_valid,
    input  logic [AW-1:0]                  deq_port,
    output logic [NPORTS-1:0]              pending,
    output logic [NPORTS-1:0][LEN_W-1:0]   len_q,
    output logic [NPORTS-1:0][BYTE_W-1:0]  seed_q,
    output logic [NPORTS-1:0]              bad_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [CNT_W-1:0] cnt;
        logic             hit;
        logic             dec;
        logic             inc;

        assign hit = enq_valid && (enq_port == AW'(p)) && (enq_len != '0);
        assign dec = deq_valid && (deq_port == AW'(p));
        assign inc = hit && ((cnt != CNT_MAX) || dec);

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt       <= '0;
                len_q[p]  <= '0;
                seed_q[p] <= '0;
                bad_q[p]  <= 1'b0;
            end else begin
                if (inc && !dec)      cnt <= cnt + 1'b1;
                else if (dec && !inc) cnt <= cnt - 1'b1;
                if (hit) begin
                    len_q[p]  <= enq_len;
                    seed_q[p] <= enq_seed;
                    bad_q[p]  <= enq_bad;
                end
            end
        end

        assign pending[p] = (cnt != '0);
    end

    AST_DEQ_HAS_PACKET: assert property (@(posedge clk) disable iff (rst)
        deq_valid |-> pending[deq_port]) else $error("dequeue from empty port"); // R8
endmodule

// File: rtl/mpkt_rr_pick.sv
module mpkt_rr_pick #(
    parameter int NPORTS = 4,
    localparam int AW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [NPORTS-1:0] req,
    input  logic [AW-1:0]     start,
    output logic              any,
    output logic [AW-1:0]     grant
);
    always_comb begin
        any   = |req;
        grant = '0;
        for (int k = NPORTS - 1; k >= 0; k--) begin
            int j;
            j = int'(start) + k;
            if (j >= NPORTS) j = j - NPORTS;
            if (req[j]) grant = AW'(j);
        end
    end
endmodule

// File: rtl/mpkt_rx_source.sv
module mpkt_rx_source
    import mpkt_rx_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int CNT_W  = 3,
    parameter int LEN_W  = 8,
    localparam int AW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lnk_rdy,
    input  logic              enq_valid,
    input  logic [AW-1:0]     enq_port,
    input  logic [LEN_W-1:0]  enq_len,
    input  logic [7:0]        enq_seed,
    input  logic              enq_bad,
    output logic [7:0]        rx_data,
    output logic              rx_sel,
    output logic              rx_val,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_err
);
    logic [NPORTS-1:0]              pending;
    logic [NPORTS-1:0][LEN_W-1:0]   len_q;
    logic [NPORTS-1:0][BYTE_W-1:0]  seed_q;
    logic [NPORTS-1:0]              bad_q;
    logic                           any;
    logic [AW-1:0]                  grant;
    logic [AW-1:0]                  ptr;
    logic                           start_sel;

    xfer_state_t        state;
    rx_beat_t           beat;
    logic [LEN_W-1:0]   cur_len;
    logic [BYTE_W-1:0]  cur_seed;
    logic               cur_bad;
    logic [LEN_W-1:0]   idx;
    logic               last_byte;

    assign start_sel = (state == ST_IDLE) && lnk_rdy && any;
    assign last_byte = (idx == cur_len - 1'b1);

    mpkt_port_queues #(.NPORTS(NPORTS), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_queues (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_port(enq_port), .enq_len(enq_len),
        .enq_seed(enq_seed), .enq_bad(enq_bad),
        .deq_valid(start_sel), .deq_port(grant),
        .pending(pending), .len_q(len_q), .seed_q(seed_q), .bad_q(bad_q)
    );

    mpkt_rr_pick #(.NPORTS(NPORTS)) u_pick (
        .req(pending), .start(ptr), .any(any), .grant(grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            beat     <= '0;
            ptr      <= '0;
            cur_len  <= '0;
            cur_seed <= '0;
            cur_bad  <= 1'b0;
            idx      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_sel) begin
                        beat      <= idle_beat(BYTE_W'(grant));
                        beat.sel  <= 1'b1;
                        cur_len   <= len_q[grant];
                        cur_seed  <= seed_q[grant];
                        cur_bad   <= bad_q[grant];
                        idx       <= '0;
                        ptr       <= (grant == AW'(NPORTS - 1)) ? '0 : grant + 1'b1;
                        state     <= ST_XFER;
                    end else begin
                        beat <= '0;
                    end
                end
                ST_XFER: begin
                    if (lnk_rdy) begin
                        beat.sel  <= 1'b0;
                        beat.val  <= 1'b1;
                        beat.sop  <= (idx == '0);
                        beat.eop  <= last_byte;
                        beat.err  <= last_byte && cur_bad;
                        beat.data <= cur_seed + BYTE_W'(idx);
                        idx       <= idx + 1'b1;
                        if (last_byte) state <= ST_IDLE;
                    end else begin
                        beat <= idle_beat(beat.data);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rx_data = beat.data;
    assign rx_sel  = beat.sel;
    assign rx_val  = beat.val;
    assign rx_sop  = beat.sop;
    assign rx_eop  = beat.eop;
    assign rx_err  = beat.err;

    AST_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        (rx_sel || rx_val) |-> $past(lnk_rdy)) else $error("transfer without ready"); // R1
    AST_ADDR_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        rx_sel |-> !rx_val) else $error("address cycle with valid"); // R2
    AST_ADDR_THEN_START: assert property (@(posedge clk) disable iff (rst)
        rx_sel |=> (!rx_sel && (!rx_val || rx_sop))) else $error("address not followed by start"); // R3
    AST_MARKERS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        (rx_sop || rx_eop) |-> rx_val) else $error("marker without valid"); // R4
    AST_EOP_THEN_DROP: assert property (@(posedge clk) disable iff (rst)
        rx_eop |=> (!rx_val && !rx_eop)) else $error("valid held past end"); // R6
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rx_val && !rx_sel && state == ST_XFER && $past(state == ST_XFER)) |-> $stable(rx_data))
        else $error("data moved during pause"); // R7
    AST_ERR_ON_EOP: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> rx_eop) else $error("error without end"); // R9
endmodule

// File: tb/mpkt_rx_source_bench.sv
module mpkt_rx_source_bench;
    localparam int NPORTS = 4;
    localparam int AW     = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lnk_rdy = 1'b0;
    logic enq_valid = 1'b0;
    logic [AW-1:0] enq_port = '0;
    logic [7:0] enq_len = '0;
    logic [7:0] enq_seed = '0;
    logic enq_bad = 1'b0;
    logic [7:0] rx_data;
    logic rx_sel, rx_val, rx_sop, rx_eop, rx_err;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    mpkt_rx_source #(.NPORTS(NPORTS), .CNT_W(3), .LEN_W(8)) u_mpkt_rx_source (
        .clk(clk), .rst(rst), .lnk_rdy(lnk_rdy),
        .enq_valid(enq_valid), .enq_port(enq_port), .enq_len(enq_len),
        .enq_seed(enq_seed), .enq_bad(enq_bad),
        .rx_data(rx_data), .rx_sel(rx_sel), .rx_val(rx_val),
        .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err)
    );

    task automatic chk(input string req, input bit s, input bit v, input bit so,
                       input bit eo, input bit er, input logic [7:0] d);
        logic [12:0] got, exp;
        @(negedge clk);
        got = {rx_sel, rx_val, rx_sop, rx_eop, rx_err, rx_data};
        exp = {s, v, so, eo, er, d};
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got sel/val/sop/eop/err=%b data=%h exp %b data=%h",
                     req, got[12:8], got[7:0], exp[12:8], exp[7:0]);
        end
    endtask

    task automatic enq(input int p, input int len, input logic [7:0] seed, input bit bad);
        enq_valid = 1'b1;
        enq_port  = AW'(p);
        enq_len   = 8'(len);
        enq_seed  = seed;
        enq_bad   = bad;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic idle_chk(input string req);
        chk(req, 0, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic test_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_chk("R11 reset outputs");
    endtask

    task automatic test_rr_after_reset;
        lnk_rdy = 1'b0;
        enq(3, 1, 8'h33, 0);
        enq(1, 1, 8'h11, 0);
        idle_chk("R1 held while not ready");
        idle_chk("R1 held while not ready");
        lnk_rdy = 1'b1;
        chk("R11 search starts at port 0", 1, 0, 0, 0, 0, 8'h01);
        chk("R5 single byte", 0, 1, 1, 1, 0, 8'h11);
        chk("R8 next port", 1, 0, 0, 0, 0, 8'h03);
        chk("R5 single byte", 0, 1, 1, 1, 0, 8'h33);
        idle_chk("R6 drop after end");
        lnk_rdy = 1'b0;
    endtask

    task automatic test_basic_packet;
        enq(2, 3, 8'h10, 0);
        lnk_rdy = 1'b1;
        chk("R2 address cycle", 1, 0, 0, 0, 0, 8'h02);
        chk("R3 first byte", 0, 1, 1, 0, 0, 8'h10);
        chk("R4 middle byte", 0, 1, 0, 0, 0, 8'h11);
        chk("R5 last byte", 0, 1, 0, 1, 0, 8'h12);
        idle_chk("R6 drop after end");
        lnk_rdy = 1'b0;
    endtask

    task automatic test_bad_single;
        enq(1, 1, 8'hA5, 1);
        lnk_rdy = 1'b1;
        chk("R2 address cycle", 1, 0, 0, 0, 0, 8'h01);
        chk("R9 error on end", 0, 1, 1, 1, 1, 8'hA5);
        idle_chk("R9 error cleared");
        lnk_rdy = 1'b0;
    endtask

    task automatic test_back_to_back;
        enq(0, 2, 8'h20, 0);
        enq(3, 2, 8'h30, 0);
        enq(2, 1, 8'h40, 0);
        lnk_rdy = 1'b1;
        chk("R8 rr from port 2", 1, 0, 0, 0, 0, 8'h02);
        chk("R5 single byte", 0, 1, 1, 1, 0, 8'h40);
        chk("R6 address right after end", 1, 0, 0, 0, 0, 8'h03);
        chk("R3 first byte", 0, 1, 1, 0, 0, 8'h30);
        chk("R5 last byte", 0, 1, 0, 1, 0, 8'h31);
        chk("R8 wrap to port 0", 1, 0, 0, 0, 0, 8'h00);
        chk("R3 first byte", 0, 1, 1, 0, 0, 8'h20);
        chk("R5 last byte", 0, 1, 0, 1, 0, 8'h21);
        idle_chk("R6 drop after end");
        lnk_rdy = 1'b0;
    endtask

    task automatic test_pause_mid_packet;
        enq(1, 4, 8'hFE, 0);
        lnk_rdy = 1'b1;
        chk("R2 address cycle", 1, 0, 0, 0, 0, 8'h01);
        chk("R3 first byte", 0, 1, 1, 0, 0, 8'hFE);
        lnk_rdy = 1'b0;
        chk("R7 pause holds byte", 0, 0, 0, 0, 0, 8'hFE);
        chk("R7 pause holds byte", 0, 0, 0, 0, 0, 8'hFE);
        lnk_rdy = 1'b1;
        chk("R7 resume no address", 0, 1, 0, 0, 0, 8'hFF);
        chk("R4 byte wraps mod 256", 0, 1, 0, 0, 0, 8'h00);
        chk("R5 last byte", 0, 1, 0, 1, 0, 8'h01);
        idle_chk("R6 drop after end");
        lnk_rdy = 1'b0;
    endtask

    task automatic test_overwrite_and_addr_pause;
        enq(2, 2, 8'h70, 1);
        enq(2, 1, 8'h80, 0);
        lnk_rdy = 1'b1;
        chk("R2 address cycle", 1, 0, 0, 0, 0, 8'h02);
        lnk_rdy = 1'b0;
        chk("R7 pause after address", 0, 0, 0, 0, 0, 8'h02);
        lnk_rdy = 1'b1;
        chk("R10 latest length seed flag", 0, 1, 1, 1, 0, 8'h80);
        chk("R10 second packet counted", 1, 0, 0, 0, 0, 8'h02);
        chk("R10 latest length seed flag", 0, 1, 1, 1, 0, 8'h80);
        idle_chk("R10 only two packets");
        lnk_rdy = 1'b0;
    endtask

    task automatic test_saturation;
        for (int i = 0; i < 8; i++) enq(0, 1, 8'h60, 0);
        enq(3, 0, 8'h99, 0);
        lnk_rdy = 1'b1;
        for (int i = 0; i < 7; i++) begin
            chk("R10 saturated queue", 1, 0, 0, 0, 0, 8'h00);
            chk("R10 saturated queue", 0, 1, 1, 1, 0, 8'h60);
        end
        idle_chk("R10 count capped at 7");
        idle_chk("R10 zero length ignored");
        lnk_rdy = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_rr_after_reset();
        test_basic_packet();
        test_bad_single();
        test_back_to_back();
        test_pause_mid_packet();
        test_overwrite_and_addr_pause();
        test_saturation();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule